// File: doc/BRIEF.md
# Host Reset Supervisor with Watchdog and Supply Monitor

This block holds a host processor in reset whenever the host or its supply cannot be trusted. Two sources drive one shared reset line. The first is a watchdog timer. The host restarts it with a kick strobe that arrives from the serial interface. If no kick comes within the selected timeout, the block drives a reset pulse of fixed length. The second is a supply monitor. It takes a digital low-voltage flag from an analog comparator that sits outside this block, together with a power-on indication. While either of these is high the reset line is held, and it stays held for a fixed stretch after both clear.

All timing is counted in ticks of a 32.768 kHz enable that is synchronous to the system clock. The watchdog timeout is chosen by a 2-bit select that software writes through a strobe. The encoding is not binary: it offers a quarter second, three quarters of a second and one and three quarter seconds, plus an off setting. The reset output is modelled as an open-drain, active-low pin. It is given as a pull-down enable together with the resulting low-active level.

Top module: `sup_reset_supervisor`

## Requirements
- R1: The select codes 2'b00, 2'b01 and 2'b10 choose timeouts of T_SHORT, T_MID and T_LONG ticks (defaults 8192, 24576, 57344). With no restart, the watchdog reset starts on the clock edge after the tick that completes the timeout, counted from the last restart.
- R2: Select code 2'b11 turns the watchdog off. The counter is held at zero and no watchdog reset occurs.
- R3: A kick strobe while no watchdog pulse is active restarts the count from zero. A timeout then needs a full period of ticks after the kick.
- R4: A select write strobe loads the new code and restarts the count from zero in the same cycle. The next timeout uses the new code. After reset the select holds 2'b10.
- R5: A watchdog reset pulse lasts exactly T_HOLD ticks (default 8192, which is 250 ms). Kicks and select writes do not shorten it. When it ends, the count restarts from zero.
- R6: A high low-voltage flag asserts reset from the next clock edge. Reset stays asserted while the flag is high, and is released on the T_HOLD-th tick after the flag and the power-on indication are both low.
- R7: The power-on indication acts the same way as the low-voltage flag. A block reset (rst_n low) starts with the reset output asserted, and the output is released after T_HOLD ticks.
- R8: While the supply hold is active, the watchdog count is held at zero, so the watchdog restarts when the hold ends.
- R9: sup_pd_en is high exactly when either source requests reset, and sup_rst_n is always its inverse.
- R10: The supply hold works the same whether the watchdog is on or off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| tick_en | input | 1 | One-cycle 32.768 kHz tick enable |
| kick | input | 1 | Watchdog restart strobe from the serial interface |
| sel_wr | input | 1 | Timeout select write strobe |
| sel_in | input | 2 | Timeout select code (00 short, 01 mid, 10 long, 11 off) |
| low_volt | input | 1 | Supply below trip threshold |
| por_in | input | 1 | Power-on indication, active high |
| sup_pd_en | output | 1 | Open-drain pull-down enable for the reset pin |
| sup_rst_n | output | 1 | Active-low reset level seen on the pin |

## Verification
The bench builds the block with T_SHORT=8, T_MID=24, T_LONG=56 and T_HOLD=8. These keep the 1:3:7 ratio of the timeouts. At this scale every timeout, every complete reset pulse, a release after power-on and the timing around each tick boundary all fall within a few hundred clocks. Random runs with sparse ticks and varying kick rates therefore reach expiry, kicks landing one tick before expiry, and low-voltage events that overlap a watchdog pulse.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        SEL_QUARTER = 2'b00,
        SEL_THREEQ  = 2'b01,
        SEL_SEVENQ  = 2'b10,
        SEL_OFF     = 2'b11
    } wdt_sel_e;

    localparam wdt_sel_e SEL_AT_RESET = SEL_SEVENQ;

endpackage

// File: rtl/sup_wdt_core.sv
module sup_wdt_core
    import sup_pkg::*;
#(
    parameter int T_SHORT = 8192,
    parameter int T_MID   = 24576,
    parameter int T_LONG  = 57344,
    parameter int T_HOLD  = 8192
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick_en,
    input  logic     kick,
    input  logic     sel_wr,
    input  wdt_sel_e sel_in,
    input  logic     supply_hold,
    output logic     wdt_fire
);

    localparam int CW = $clog2(T_LONG + 1);
    localparam int HW = $clog2(T_HOLD + 1);

    typedef struct packed {
        wdt_sel_e        sel;
        logic            fire;
        logic [CW-1:0]   cnt;
        logic [HW-1:0]   hcnt;
    } wdt_st_t;

    wdt_st_t st_d, st_q;
    logic [CW-1:0] limit_m1;

    always_comb begin
        case (st_q.sel)
            SEL_QUARTER: limit_m1 = CW'(T_SHORT - 1);
            SEL_THREEQ:  limit_m1 = CW'(T_MID - 1);
            default:     limit_m1 = CW'(T_LONG - 1);
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (sel_wr) begin
            st_d.sel = sel_in;
        end
        if (st_q.fire) begin
            if (tick_en) begin
                if (st_q.hcnt == HW'(T_HOLD - 1)) begin
                    st_d.fire = 1'b0;
                    st_d.hcnt = '0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.hcnt = st_q.hcnt + 1'b1;
                end
            end
        end else if (supply_hold || st_q.sel == SEL_OFF || kick || sel_wr) begin
            st_d.cnt = '0;
        end else if (tick_en) begin
            if (st_q.cnt == limit_m1) begin
                st_d.fire = 1'b1;
                st_d.hcnt = '0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel  <= SEL_AT_RESET;
            st_q.fire <= 1'b0;
            st_q.cnt  <= '0;
            st_q.hcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wdt_fire = st_q.fire;

    // R2: an off setting never lets a pulse start
    a_r2_off_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel == SEL_OFF && !st_q.fire) |=> !st_q.fire);

    // R5: pulse edges only on a tick
    a_r5_fire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.fire) || $fell(st_q.fire)) |-> $past(tick_en));

    // R3: a kick outside a pulse leaves the count at zero
    a_r3_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !st_q.fire) |=> (st_q.cnt == '0 && !st_q.fire));

    // R8: supply hold blocks the start of a watchdog pulse
    a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_hold && !st_q.fire) |=> !st_q.fire);

endmodule

// File: rtl/sup_hold_stretch.sv
module sup_hold_stretch #(
    parameter int T_HOLD = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic low_volt,
    input  logic por_in,
    output logic supply_hold
);

    localparam int HW = $clog2(T_HOLD + 1);

    typedef struct packed {
        logic          hold;
        logic [HW-1:0] hcnt;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     cond;

    assign cond = low_volt | por_in;

    always_comb begin
        st_d = st_q;
        if (cond) begin
            st_d.hold = 1'b1;
            st_d.hcnt = '0;
        end else if (st_q.hold && tick_en) begin
            if (st_q.hcnt == HW'(T_HOLD - 1)) begin
                st_d.hold = 1'b0;
                st_d.hcnt = '0;
            end else begin
                st_d.hcnt = st_q.hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b1;
            st_q.hcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign supply_hold = st_q.hold;

    // R6 / R7: a supply or power-on condition asserts the hold next cycle
    a_r6_cond_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        cond |=> st_q.hold);

    // R6: release only on a tick with the condition gone
    a_r6_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold) |-> ($past(tick_en) && !$past(cond)));

endmodule

// File: rtl/sup_reset_supervisor.sv
module sup_reset_supervisor
    import sup_pkg::*;
#(
    parameter int T_SHORT = 8192,
    parameter int T_MID   = 24576,
    parameter int T_LONG  = 57344,
    parameter int T_HOLD  = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       kick,
    input  logic       sel_wr,
    input  logic [1:0] sel_in,
    input  logic       low_volt,
    input  logic       por_in,
    output logic       sup_pd_en,
    output logic       sup_rst_n
);

    logic wdt_fire;
    logic supply_hold;

    sup_hold_stretch #(.T_HOLD(T_HOLD)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .low_volt    (low_volt),
        .por_in      (por_in),
        .supply_hold (supply_hold)
    );

    sup_wdt_core #(
        .T_SHORT (T_SHORT),
        .T_MID   (T_MID),
        .T_LONG  (T_LONG),
        .T_HOLD  (T_HOLD)
    ) u_wdt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .kick        (kick),
        .sel_wr      (sel_wr),
        .sel_in      (wdt_sel_e'(sel_in)),
        .supply_hold (supply_hold),
        .wdt_fire    (wdt_fire)
    );

    assign sup_pd_en = wdt_fire | supply_hold;
    assign sup_rst_n = ~sup_pd_en;

    // R6: the pin is low in the cycle after a low-voltage flag
    a_r6_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        low_volt |=> !sup_rst_n);

endmodule

// File: tb/test_sup_reset_supervisor.sv
`timescale 1ns/1ps
module test_sup_reset_supervisor;

    localparam int TS = 8, TM = 24, TL = 56, TH = 8;

    logic clk = 0, rst_n = 0;
    logic tick_en = 0, kick = 0, sel_wr = 0, low_volt = 0, por_in = 0;
    logic [1:0] sel_in = 0;
    logic sup_pd_en, sup_rst_n;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string tag = "R7";

    // reference state
    bit m_fire, m_hold;
    int m_cnt, m_fcnt, m_hcnt;
    int m_sel;

    sup_reset_supervisor #(.T_SHORT(TS), .T_MID(TM), .T_LONG(TL), .T_HOLD(TH))
    i_sup_reset_supervisor (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick(kick),
        .sel_wr(sel_wr), .sel_in(sel_in), .low_volt(low_volt), .por_in(por_in),
        .sup_pd_en(sup_pd_en), .sup_rst_n(sup_rst_n)
    );

    always #2 clk = ~clk;

    function automatic int limit_of(int s);
        return (s == 0) ? TS : (s == 1) ? TM : TL;
    endfunction

    task automatic model_reset();
        m_fire = 0; m_hold = 1; m_cnt = 0; m_fcnt = 0; m_hcnt = 0; m_sel = 2;
    endtask

    task automatic model_step(bit tk, bit kk, bit wr, int s, bit lv, bit po);
        bit old_hold = m_hold;
        int old_sel = m_sel;
        if (lv || po) begin
            m_hold = 1; m_hcnt = 0;
        end else if (m_hold && tk) begin
            if (m_hcnt == TH - 1) begin m_hold = 0; m_hcnt = 0; end
            else m_hcnt++;
        end
        if (wr) m_sel = s;
        if (m_fire) begin
            if (tk) begin
                if (m_fcnt == TH - 1) begin m_fire = 0; m_fcnt = 0; m_cnt = 0; end
                else m_fcnt++;
            end
        end else if (old_hold || old_sel == 3 || kk || wr) begin
            m_cnt = 0;
        end else if (tk) begin
            if (m_cnt == limit_of(old_sel) - 1) begin m_fire = 1; m_fcnt = 0; m_cnt = 0; end
            else m_cnt++;
        end
    endtask

    task automatic check_now();
        bit exp_pd = m_fire | m_hold;
        n_chk++;
        if (sup_pd_en !== exp_pd || sup_rst_n !== !exp_pd) begin
            n_bad++;
            $display("FAIL %s cycle %0d: pd_en=%b rst_n=%b expected pd_en=%b rst_n=%b (R9 pairing)",
                     tag, cyc, sup_pd_en, sup_rst_n, exp_pd, !exp_pd);
        end
    endtask

    task automatic step(bit tk, bit kk, bit wr, int s, bit lv, bit po);
        @(negedge clk);
        check_now();
        tick_en = tk; kick = kk; sel_wr = wr; sel_in = 2'(s);
        low_volt = lv; por_in = po;
        model_step(tk, kk, wr, s, lv, po);
    endtask

    task automatic run(int n, int tk_pct, int kk_pct, int wr_pct, int lv_pct, int po_pct);
        for (int i = 0; i < n; i++) begin
            step(($urandom % 100) < tk_pct, ($urandom % 100) < kk_pct,
                 ($urandom % 100) < wr_pct, int'($urandom % 4),
                 ($urandom % 100) < lv_pct, ($urandom % 100) < po_pct);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run hung at cycle %0d, expected end before 150000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        tag = "R7";                                  // R7: reset state asserted
        check_now();
        rst_n = 1;
        run(20, 100, 0, 0, 0, 0);                    // R7: release after TH ticks
        tag = "R1";                                  // R1: long timeout from reset select
        run(70, 100, 0, 0, 0, 0);
        tag = "R4";                                  // R4: write short select, restart
        step(1, 0, 1, 0, 0, 0);
        run(30, 100, 0, 0, 0, 0);
        tag = "R5";                                  // R5: kicks during pulse ignored
        run(60, 100, 60, 0, 0, 0);
        tag = "R3";                                  // R3: kick one tick before expiry
        step(0, 0, 1, 1, 0, 0);
        run(TM - 1, 100, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0);
        run(TM + 4, 100, 0, 0, 0, 0);
        tag = "R2";                                  // R2: off never fires
        step(0, 0, 1, 3, 0, 0);
        run(300, 100, 0, 0, 0, 0);
        tag = "R10";                                 // R10: supply hold while off
        run(200, 50, 0, 0, 5, 0);
        tag = "R6";                                  // R6: low-voltage stretch, sparse ticks
        step(0, 0, 1, 0, 0, 0);
        run(400, 30, 2, 0, 3, 0);
        tag = "R8";                                  // R8: long hold keeps watchdog cleared
        run(60, 100, 0, 0, 100, 0);
        run(40, 100, 0, 0, 0, 0);
        tag = "R7";                                  // R7: power-on indication
        run(300, 40, 3, 1, 0, 3);
        tag = "R9";                                  // R9: mixed random traffic
        for (int k = 0; k < 8; k++) run(1500, 20 + 10 * k, k, 1, 1, 1);
        tag = "R1";                                  // R1: each select expires, no kicks
        for (int s = 0; s < 3; s++) begin
            step(0, 0, 1, s, 0, 0);
            run(limit_of(s) + TH + 20, 100, 0, 0, 0, 0);
        end
        summary();
        $finish;
    end

endmodule